// File: doc/BRIEF.md
# Prime-Field Adder/Subtractor for the secp256k1 Field

This block adds or subtracts two 256-bit field elements modulo the prime p = 2^256 − 2^32 − 977. Both operands must already be below p. The block always returns a fully reduced result in the range [0, p). A one-bit opcode selects the operation. Operands enter through a valid/ready handshake, and the result leaves through a second valid/ready handshake after exactly one clock.

The datapath works in constant time. Every cycle it builds the raw sum and the raw difference. It also builds the corrected form of each: the sum plus 2^256 − p, and the difference plus p. A final mux picks one value, so the timing and the path taken never depend on the operand values. The test of whether the sum is at least p compares the sum with p limb by limb, from the most significant limb down.

Top module: `modp_addsub`

## Requirements
- R1: With `in_sub` = 0, the result is (a + b) mod p for any a, b < p.
- R2: When the 257-bit sum carries out of bit 255, the result is the low 256 bits of the sum plus 0x1000003D1, with the carry out of bit 255 discarded. For example, a = b = p − 1 gives p − 2.
- R3: When the sum has no carry out but is at least p, 0x1000003D1 is added to it. A sum exactly equal to p gives 0, and a sum of p − 1 + 2^32 gives 2^32 − 1.
- R4: With `in_sub` = 1, the result is (a − b) mod p. When the subtraction borrows, p is added back. For example, a = 0 and b = p − 1 gives 1.
- R5: A subtraction with no borrow returns the raw difference unchanged, so a = b gives 0.
- R6: `in_sub` encodes the operation: 0 selects addition and 1 selects subtraction.
- R7: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high right after that same edge, for all operand values.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A result that is handed off with no new operation accepted leaves `out_valid` low.
- R9: While `out_valid` is high and `out_ready` is low, `out_res` and `out_valid` hold their values.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.
- R11: Whenever `out_valid` is high, `out_res` is below p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_sub | input | 1 | 0 = add, 1 = subtract |
| in_a | input | 256 | First operand, below p |
| in_b | input | 256 | Second operand, below p |
| out_valid | output | 1 | Result held on `out_res` |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 256 | Reduced result |

## Verification
Random reduced operands almost never produce a sum that falls in the narrow band [p, 2^256). They also almost never produce a sum that lands exactly on p. Either event needs the operands to sit within about 2^32 of a precise value, so the branch that decides on the lowest limb stays unreached under random stimulus. The bench therefore first drives a fixed list of chosen pairs:
- p − 1 with 1, whose sum is exactly p;
- p − 1 with 2^32, whose sum is at least p with no carry out;
- p − 1 with p − 1, whose sum carries out;
- equal operands under subtraction;
- 0 − (p − 1), which borrows.

It then runs random pairs while `out_ready` toggles at random, which exercises stalls and back-to-back transfers.

// File: rtl/modp_addsub.sv
module modp_addsub #(
  parameter int LW = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_sub,
  input  logic [255:0] in_a,
  input  logic [255:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [255:0] out_res
);
  localparam int W  = 256;
  localparam int NL = W / LW;
  localparam logic [W-1:0] P  = 256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F;
  localparam logic [W-1:0] PC = ~P + W'(1);

  logic [W:0]    sum_w, dif_w;
  logic [NL-1:0] l_gt, l_lt;
  logic          sum_ge;
  logic [W-1:0]  add_fix, sub_fix, add_res, sub_res, nxt;
  logic          fire;

  assign sum_w = {1'b0, in_a} + {1'b0, in_b};
  assign dif_w = {1'b0, in_a} - {1'b0, in_b};

  for (genvar i = 0; i < NL; i++) begin : g_limb
    assign l_gt[i] = sum_w[i*LW +: LW] > P[i*LW +: LW];
    assign l_lt[i] = sum_w[i*LW +: LW] < P[i*LW +: LW];
  end

  always_comb begin
    sum_ge = 1'b1;
    for (int i = 0; i < NL; i++) begin
      if (l_gt[i])      sum_ge = 1'b1;
      else if (l_lt[i]) sum_ge = 1'b0;
    end
  end

  assign add_fix = sum_w[W-1:0] + PC;
  assign sub_fix = dif_w[W-1:0] + P;
  assign add_res = (sum_w[W] | sum_ge) ? add_fix : sum_w[W-1:0];
  assign sub_res = dif_w[W] ? sub_fix : dif_w[W-1:0];
  assign nxt     = in_sub ? sub_res : add_res;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (fire)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_res <= '0;
    else if (fire) out_res <= nxt;
  end

  a_r11_below_p: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_res < P);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res));
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
  a_r5_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sub && (in_a == in_b) |=> out_res == '0);
  a_r3_exact_p: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_sub && ({1'b0, in_a} + {1'b0, in_b} == {1'b0, P}) |=> out_res == '0);
endmodule

// File: tb/sim_modp_addsub.sv
module sim_modp_addsub;
  localparam logic [257:0] PW = 258'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F;
  localparam logic [255:0] P  = PW[255:0];

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sub = 0, out_ready = 0;
  logic [255:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [255:0] out_res;
  int checks = 0, fails = 0;
  logic done = 0;

  always #10 clk = ~clk;

  modp_addsub u0 (.clk, .rst_n, .in_valid, .in_ready, .in_sub, .in_a, .in_b,
                  .out_valid, .out_ready, .out_res);

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] ref_op(input logic sub, input logic [255:0] a, input logic [255:0] b);
    logic [257:0] t;
    if (sub) t = ({2'b0, a} + PW - {2'b0, b}) % PW;
    else     t = ({2'b0, a} + {2'b0, b}) % PW;
    return t[255:0];
  endfunction

  function automatic logic [255:0] rnd_elem();
    logic [257:0] t = '0;
    for (int k = 0; k < 8; k++) t[k*32 +: 32] = $urandom;
    if ($urandom_range(0, 7) == 0) t[255:224] = 32'hFFFFFFFF;
    return 256'(t % PW);
  endfunction

  // directed corner list: op, a, b, tag
  localparam int ND = 9;
  logic         d_sub [ND];
  logic [255:0] d_a [ND], d_b [ND];
  string        d_tag [ND];

  initial begin
    d_sub[0]=0; d_a[0]=P-1;         d_b[0]=256'd1;      d_tag[0]="R3";
    d_sub[1]=0; d_a[1]=P-1;         d_b[1]=P-1;         d_tag[1]="R2";
    d_sub[2]=0; d_a[2]=P-1;         d_b[2]=256'h1_0000_0000; d_tag[2]="R3";
    d_sub[3]=1; d_a[3]=256'h1234_5678_9abc; d_b[3]=256'h1234_5678_9abc; d_tag[3]="R5";
    d_sub[4]=1; d_a[4]='0;          d_b[4]=P-1;         d_tag[4]="R4";
    d_sub[5]=0; d_a[5]='0;          d_b[5]='0;          d_tag[5]="R1";
    d_sub[6]=1; d_a[6]=256'd5;      d_b[6]=256'd3;      d_tag[6]="R6";
    d_sub[7]=0; d_a[7]=256'd5;      d_b[7]=256'd3;      d_tag[7]="R6";
    d_sub[8]=1; d_a[8]=256'd3;      d_b[8]=256'd5;      d_tag[8]="R4";
  end

  initial begin : wdog
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic m_valid;
    logic [255:0] m_res;
    string m_tag;
    int idx;
    logic pend;
    string p_tag;
    m_valid = 0; m_res = '0; m_tag = "R1"; idx = 0; pend = 0; p_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++; if (out_valid !== 1'b0) begin fails++; $display("FAIL R10 out_valid actual=%b expected=0", out_valid); end
    checks++; if (in_ready !== 1'b1) begin fails++; $display("FAIL R10 in_ready actual=%b expected=1", in_ready); end

    for (int cyc = 0; cyc < 3000; cyc++) begin
      // observe state after the previous edge
      checks++;
      if (out_valid !== m_valid) begin
        fails++; $display("FAIL R7 out_valid actual=%b expected=%b", out_valid, m_valid);
      end
      if (m_valid) chk((m_tag == "R1") ? "R1/R11" : m_tag, out_res, m_res);
      // new stimulus
      if (!pend && $urandom_range(0, 3) != 0) begin
        pend = 1;
        if (idx < ND) begin
          in_sub = d_sub[idx]; in_a = d_a[idx]; in_b = d_b[idx]; p_tag = d_tag[idx]; idx++;
        end else begin
          in_sub = $urandom_range(0, 1)[0]; in_a = rnd_elem(); in_b = rnd_elem();
          if ($urandom_range(0, 9) == 0) in_b = in_a;
          p_tag = in_sub ? "R4" : "R1";
        end
      end
      in_valid = pend;
      out_ready = ($urandom_range(0, 2) != 0);
      #1;
      checks++;
      if (in_ready !== (!m_valid || out_ready)) begin
        fails++; $display("FAIL R8 in_ready actual=%b expected=%b", in_ready, !m_valid || out_ready);
      end
      // model the coming edge
      if (in_valid && (!m_valid || out_ready)) begin
        m_valid = 1; m_res = ref_op(in_sub, in_a, in_b); m_tag = p_tag; pend = 0;
      end else if (out_ready) begin
        m_valid = 0;
      end else if (m_valid) begin
        m_tag = "R9";
      end
      @(negedge clk);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule